// File: doc/BRIEF.md
# Embedded video timing code inserter

This block sits on a 4:2:2 pixel path and replaces selected pixel slots with timing event codes. A receiver can then rebuild line and field timing from the data lanes alone, without separate sync wires. Each clock is one pixel slot carrying a luma word and a chroma word. An event slot carries a chroma phase word on the chroma lane and an event name on the luma lane. On a serialised link the chroma word goes out first, so every event is a phase word followed by an event word.

The block detects edges on the video-active qualifier (start and end of active video), on the horizontal reference (line code) and on the vertical reference (field code). It holds back a line code that arrives while active data is still running, and it arbitrates between events that are waiting. Pixel samples are clamped so that reserved code values never appear as data. An optional window mode builds the active qualifier from slot counts after each line edge, so every line carries the same number of data words. The line state machine has two states. S_BLANK moves to S_LIVE on the transition named OPEN, when active rises. S_LIVE moves back to S_BLANK on the transition named CLOSE, when active falls.

Top module: `tcode_inserter`

## Requirements
- R1: During and right after reset, every output slot is idle: luma 0x10, chroma 0x80, out_code 0 and out_data 0.
- R2: An output appears one clock after its input slot. In an event slot, out_code is 1, out_data is 0 and out_c is 0xFF for a Cb slot or 0xFE for a Cr slot. The phase is Cb in the slot where active rises, and it alternates on every slot after that.
- R3: A rising edge of the effective active qualifier queues a start code (luma 0x10). A falling edge sends an end code (luma 0x20) in that same slot. Data slots (out_data 1, clamped pixels) appear only while active is high and after the start code has gone out.
- R4: A rising edge of in_href queues a line code. The code is luma 0x30 if active was high at any point since the previous line edge, and luma 0x40 otherwise.
- R5: A line code goes out only in a slot whose preceding slot had active low. A line edge that arrives during active data therefore leaves its code in the slot right after the end code.
- R6: A falling edge of in_vref queues a field code. The code is luma 0x50 if in_href is low at that edge (odd field) and luma 0x60 if in_href is high (even field).
- R7: At most one event is sent per slot. The order of precedence is end code, line code, field code, start code. A field code waits while any line code is pending. Pixels in slots taken by events are dropped, and the input is never stalled.
- R8: Data words are clamped to the range 2..253 on both lanes, so 0, 1, 254 and 255 never appear as data.
- R9: With cfg_win_en at 1, the active qualifier is high when n is at least cfg_win_start and below cfg_win_end. Here n is the slot count since the last in_href rising edge: 0 in the edge slot, saturating at its maximum. Before the first edge n is at its maximum.
- R10: If active falls while its start code is still waiting, neither a start code nor an end code is sent for that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_y | input | DW | Luma sample |
| in_c | input | DW | Chroma sample |
| in_act | input | 1 | External video-active qualifier |
| in_href | input | 1 | Horizontal reference, rising edge starts a line |
| in_vref | input | 1 | Vertical reference, falling edge marks a field |
| cfg_win_en | input | 1 | Select the counted active window |
| cfg_win_start | input | CW | First active slot count |
| cfg_win_end | input | CW | First inactive slot count |
| out_y | output | DW | Luma lane: pixel, event code or blank |
| out_c | output | DW | Chroma lane: pixel, phase word or blank |
| out_code | output | 1 | Slot carries an event |
| out_data | output | 1 | Slot carries a pixel |

## Verification
The bench builds the block with 8-bit samples and an 8-bit slot counter. With a counter that narrow, saturation can be reached in short blank stretches, and a window end at the counter maximum shows that a saturated count stays inactive. Sample sweeps push every byte value through both lanes, which exercises both clamp bounds. Lines that run into the next line edge produce deferred line codes, including a field code that must wait behind one. Single-slot bursts that coincide with a line edge exercise the dropped start and end pair.

// File: rtl/tcode_pkg.sv
package tcode_pkg;

    typedef enum logic {S_BLANK, S_LIVE} line_st_t;

    typedef enum logic [2:0] {
        EV_NONE, EV_SAV, EV_EAV, EV_HACT, EV_HBLK, EV_VODD, EV_VEVN
    } ev_t;

    // 8-bit event name; scaled by the user for wider samples
    function automatic logic [7:0] ev_base(ev_t e);
        logic [7:0] v;
        unique case (e)
            EV_SAV:  v = 8'h10;
            EV_EAV:  v = 8'h20;
            EV_HACT: v = 8'h30;
            EV_HBLK: v = 8'h40;
            EV_VODD: v = 8'h50;
            EV_VEVN: v = 8'h60;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tcode_window.sv
module tcode_window #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          href_rise,
    input  logic [CW-1:0] cfg_start,
    input  logic [CW-1:0] cfg_end,
    output logic          win_act
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_now;

    always_comb begin
        if (href_rise)
            cnt_now = '0;
        else if (cnt_q == CNT_MAX)
            cnt_now = CNT_MAX;
        else
            cnt_now = cnt_q + 1'b1;
        win_act = (cnt_now >= cfg_start) && (cnt_now < cfg_end);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_MAX;
        else
            cnt_q <= cnt_now;
    end
endmodule

// File: rtl/tcode_clamp.sv
module tcode_clamp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam logic [DW-1:0] LO = DW'(2);
    localparam logic [DW-1:0] HI = {DW{1'b1}} - DW'(2);

    always_comb begin
        if (din < LO)
            dout = LO;
        else if (din > HI)
            dout = HI;
        else
            dout = din;
    end
endmodule

// File: rtl/tcode_sched.sv
module tcode_sched
    import tcode_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          href_lvl,
    input  logic          href_rise,
    input  logic          vref_fall,
    input  logic [DW-1:0] pix_y,
    input  logic [DW-1:0] pix_c,
    output logic [DW-1:0] o_y,
    output logic [DW-1:0] o_c,
    output logic          o_code,
    output logic          o_data
);
    localparam int SH = DW - 8;
    localparam logic [DW-1:0] PH_CB   = {DW{1'b1}};
    localparam logic [DW-1:0] PH_CR   = {DW{1'b1}} - DW'(1);
    localparam logic [DW-1:0] BLANK_Y = DW'(16) << SH;
    localparam logic [DW-1:0] BLANK_C = DW'(128) << SH;

    line_st_t st_q, st_d;
    logic sav_q, sav_d;
    logic h_q, h_d, hk_q, hk_d;
    logic v_q, v_d, vf_q, vf_d;
    logic seen_q, seen_d;
    logic ph_q, ph_d, ph_now;
    logic rise, fall, send_data;
    ev_t  ev;

    logic [DW-1:0] y_n, c_n;
    logic          code_n, data_n;

    // next-state and event selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_BLANK: if (act)  st_d = S_LIVE;   // OPEN
            S_LIVE:  if (!act) st_d = S_BLANK;  // CLOSE
        endcase
        rise   = act && (st_q == S_BLANK);
        fall   = !act && (st_q == S_LIVE);
        ph_now = rise ? 1'b0 : ph_q;
        ph_d   = ~ph_now;

        sav_d  = sav_q | rise;
        h_d    = h_q | href_rise;
        hk_d   = href_rise ? seen_q : hk_q;
        seen_d = href_rise ? act : (seen_q | act);
        v_d    = v_q | vref_fall;
        vf_d   = vref_fall ? href_lvl : vf_q;

        ev = EV_NONE;
        if (fall && sav_q) begin
            sav_d = 1'b0;                     // burst never opened
        end else if (fall) begin
            ev = EV_EAV;
        end
        if (ev == EV_NONE) begin
            if (h_d && (st_q == S_BLANK)) begin
                ev  = hk_d ? EV_HACT : EV_HBLK;
                h_d = 1'b0;
            end else if (v_d && !h_d) begin
                ev  = vf_d ? EV_VEVN : EV_VODD;
                v_d = 1'b0;
            end else if (sav_d) begin
                ev    = EV_SAV;
                sav_d = 1'b0;
            end
        end
        send_data = act && !sav_d && (ev == EV_NONE);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_BLANK;
            sav_q  <= 1'b0;
            h_q    <= 1'b0;
            hk_q   <= 1'b0;
            v_q    <= 1'b0;
            vf_q   <= 1'b0;
            seen_q <= 1'b0;
            ph_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            sav_q  <= sav_d;
            h_q    <= h_d;
            hk_q   <= hk_d;
            v_q    <= v_d;
            vf_q   <= vf_d;
            seen_q <= seen_d;
            ph_q   <= ph_d;
        end
    end

    // output words
    always_comb begin
        y_n    = BLANK_Y;
        c_n    = BLANK_C;
        code_n = 1'b0;
        data_n = 1'b0;
        if (ev != EV_NONE) begin
            code_n = 1'b1;
            c_n    = ph_now ? PH_CR : PH_CB;
            y_n    = DW'(ev_base(ev)) << SH;
        end else if (send_data) begin
            data_n = 1'b1;
            y_n    = pix_y;
            c_n    = pix_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_y    <= BLANK_Y;
            o_c    <= BLANK_C;
            o_code <= 1'b0;
            o_data <= 1'b0;
        end else begin
            o_y    <= y_n;
            o_c    <= c_n;
            o_code <= code_n;
            o_data <= data_n;
        end
    end
endmodule

// File: rtl/tcode_inserter.sv
module tcode_inserter #(
    parameter int DW = 8,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_c,
    input  logic          in_act,
    input  logic          in_href,
    input  logic          in_vref,
    input  logic          cfg_win_en,
    input  logic [CW-1:0] cfg_win_start,
    input  logic [CW-1:0] cfg_win_end,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_c,
    output logic          out_code,
    output logic          out_data
);
    localparam int LANES = 2;

    logic href_q, vref_q;
    logic href_rise, vref_fall;
    logic win_act, act_eff;
    logic [DW-1:0] lane_in  [LANES];
    logic [DW-1:0] lane_out [LANES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            href_q <= 1'b0;
            vref_q <= 1'b0;
        end else begin
            href_q <= in_href;
            vref_q <= in_vref;
        end
    end

    assign href_rise = in_href & ~href_q;
    assign vref_fall = ~in_vref & vref_q;

    tcode_window #(.CW(CW)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .href_rise (href_rise),
        .cfg_start (cfg_win_start),
        .cfg_end   (cfg_win_end),
        .win_act   (win_act)
    );

    assign act_eff    = cfg_win_en ? win_act : in_act;
    assign lane_in[0] = in_y;
    assign lane_in[1] = in_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tcode_clamp #(.DW(DW)) u_clamp (
            .din  (lane_in[g]),
            .dout (lane_out[g])
        );
    end

    tcode_sched #(.DW(DW)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act_eff),
        .href_lvl  (in_href),
        .href_rise (href_rise),
        .vref_fall (vref_fall),
        .pix_y     (lane_out[0]),
        .pix_c     (lane_out[1]),
        .o_y       (out_y),
        .o_c       (out_c),
        .o_code    (out_code),
        .o_data    (out_data)
    );
endmodule

// File: rtl/tcode_inserter_chk.sv
module tcode_inserter_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_act,
    input logic          cfg_win_en,
    input logic [DW-1:0] out_y,
    input logic [DW-1:0] out_c,
    input logic          out_code,
    input logic          out_data
);
    localparam logic [DW-1:0] LO    = DW'(2);
    localparam logic [DW-1:0] HI    = {DW{1'b1}} - DW'(2);
    localparam logic [DW-1:0] PH_CB = {DW{1'b1}};
    localparam logic [DW-1:0] PH_CR = {DW{1'b1}} - DW'(1);
    localparam logic [DW-1:0] HACT  = DW'(8'h30) << (DW - 8);
    localparam logic [DW-1:0] HBLK  = DW'(8'h40) << (DW - 8);

    a_r8_clamp_y: assert property (@(posedge clk) disable iff (!rst_n)
        out_data |-> (out_y >= LO && out_y <= HI));

    a_r8_clamp_c: assert property (@(posedge clk) disable iff (!rst_n)
        out_data |-> (out_c >= LO && out_c <= HI));

    a_r2_phase_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_code |-> (out_c == PH_CB || out_c == PH_CR));

    a_r2_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_code && out_data));

    a_r3_data_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data && !$past(cfg_win_en)) |-> $past(in_act));

    a_r5_line_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_code && (out_y == HACT || out_y == HBLK)) |-> !$past(out_data));
endmodule

bind tcode_inserter tcode_inserter_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_act     (in_act),
    .cfg_win_en (cfg_win_en),
    .out_y      (out_y),
    .out_c      (out_c),
    .out_code   (out_code),
    .out_data   (out_data)
);

// File: tb/tcode_inserter_tb.sv
module tcode_inserter_tb;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_y = '0, in_c = '0;
    logic          in_act = 1'b0, in_href = 1'b0, in_vref = 1'b0;
    logic          cfg_win_en = 1'b0;
    logic [CW-1:0] cfg_win_start = '0, cfg_win_end = '0;
    logic [DW-1:0] out_y, out_c;
    logic          out_code, out_data;

    tcode_inserter #(.DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_y(in_y), .in_c(in_c),
        .in_act(in_act), .in_href(in_href), .in_vref(in_vref),
        .cfg_win_en(cfg_win_en), .cfg_win_start(cfg_win_start),
        .cfg_win_end(cfg_win_end), .out_y(out_y), .out_c(out_c),
        .out_code(out_code), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    int m_live, m_sav, m_h, m_hk, m_hdef, m_v, m_vf, m_seen, m_ph;
    int m_cnt, m_href, m_vref;
    int e_y = 16, e_c = 128, e_code = 0, e_data = 0;
    string tag = "R1";

    function automatic int clampv(int v);
        if (v < 2) return 2;
        if (v > 253) return 253;
        return v;
    endfunction

    always @(posedge clk) begin
        int hr, vf, a, rise, fall, ph, eav, ev_y;
        cyc++;
        if (!rst_n) begin
            m_live = 0; m_sav = 0; m_h = 0; m_hk = 0; m_hdef = 0; m_v = 0;
            m_vf = 0; m_seen = 0; m_ph = 0; m_cnt = CMAX; m_href = 0; m_vref = 0;
            e_y = 16; e_c = 128; e_code = 0; e_data = 0; tag = "R1";
        end else begin
            hr = (in_href && !m_href) ? 1 : 0;
            vf = (!in_vref && m_vref) ? 1 : 0;
            m_href = in_href; m_vref = in_vref;
            if (hr) m_cnt = 0; else if (m_cnt < CMAX) m_cnt++;
            if (cfg_win_en) a = (m_cnt >= int'(cfg_win_start) && m_cnt < int'(cfg_win_end)) ? 1 : 0;
            else a = in_act ? 1 : 0;
            rise = (a && !m_live) ? 1 : 0;
            fall = (!a && m_live) ? 1 : 0;
            ph = rise ? 0 : m_ph;
            if (rise) m_sav = 1;
            eav = 0;
            tag = cfg_win_en ? "R9" : "R3";
            if (fall) begin
                if (m_sav) begin m_sav = 0; tag = "R10"; end
                else eav = 1;
            end
            if (hr) begin m_h = 1; m_hk = m_seen; m_hdef = (m_live && a) ? 1 : 0; end
            m_seen = hr ? a : ((m_seen || a) ? 1 : 0);
            if (vf) begin m_v = 1; m_vf = in_href ? 1 : 0; end
            ev_y = 0;
            if (eav) ev_y = 8'h20;
            else if (m_h && !m_live) begin
                ev_y = m_hk ? 8'h30 : 8'h40; m_h = 0;
                tag = m_hdef ? "R5" : "R4";
            end else if (m_v && !m_h) begin
                ev_y = m_vf ? 8'h60 : 8'h50; m_v = 0;
                tag = a ? "R7" : "R6";
            end else if (m_sav) begin
                ev_y = 8'h10; m_sav = 0; tag = "R2 R3";
            end
            e_code = 0; e_data = 0; e_y = 16; e_c = 128;
            if (ev_y != 0) begin
                e_code = 1; e_y = ev_y; e_c = ph ? 8'hFE : 8'hFF;
            end else if (a && !m_sav) begin
                e_data = 1; e_y = clampv(int'(in_y)); e_c = clampv(int'(in_c));
                if (!cfg_win_en) tag = "R8";
            end
            m_live = a; m_ph = ph ? 0 : 1;
        end
    end

    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            n_chk++;
            if (int'(out_y) != e_y || int'(out_c) != e_c ||
                int'(out_code) != e_code || int'(out_data) != e_data) begin
                n_bad++;
                $display("FAIL %s cyc %0d: got y=%02h c=%02h code=%0d data=%0d exp y=%02h c=%02h code=%0d data=%0d",
                         tag, cyc, out_y, out_c, out_code, out_data, e_y, e_c, e_code, e_data);
            end
        end
    end

    task automatic run_line(input int len, input int a0, input int a1,
                            input int hw, input int vat, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_href = (i < hw);
            in_act  = (i >= a0 && i < a1);
            if (i == 0) in_vref = 1'b1;
            if (vat > 0 && i == vat) in_vref = 1'b0;
            in_y = DW'((seed + i * 37) % 256);
            in_c = DW'((seed * 3 + i * 53 + 1) % 256);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);   // R1 idle outputs during reset
        rst_n = 1'b1;
        repeat (3) @(negedge clk);   // R1 idle after reset
        // blank lines, odd and even field codes (R4 R6)
        run_line(30, 0, 0, 4, 10, 1);
        run_line(30, 0, 0, 4, 2, 2);
        // active lines with clamp sweep (R2 R3 R8)
        run_line(300, 20, 280, 4, -1, 3);
        run_line(40, 5, 30, 4, -1, 4);
        // active runs into next line edge: deferred line code (R5),
        // field code waiting behind it (R7)
        run_line(40, 10, 40, 4, -1, 5);
        run_line(40, 0, 25, 6, 2, 6);
        run_line(30, 0, 0, 4, -1, 7);
        // burst opening at the line edge, one slot long: dropped (R10)
        run_line(20, 0, 1, 3, -1, 8);
        run_line(20, 0, 0, 3, -1, 9);
        // start and line edge together, longer burst
        run_line(20, 0, 8, 3, -1, 10);
        // counted window (R9)
        cfg_win_en = 1'b1; cfg_win_start = 8'd5; cfg_win_end = 8'd20;
        run_line(40, 0, 40, 4, -1, 11);
        run_line(40, 0, 40, 4, 8, 12);
        cfg_win_start = 8'd0; cfg_win_end = 8'd12;
        run_line(30, 0, 0, 4, -1, 13);
        cfg_win_start = 8'd10; cfg_win_end = 8'd10;
        run_line(30, 0, 30, 4, -1, 14);
        cfg_win_start = 8'd250; cfg_win_end = 8'd255;
        run_line(300, 0, 0, 4, -1, 15);
        cfg_win_en = 1'b0;
        // assorted lines
        for (int k = 0; k < 40; k++) begin
            int len, a0, a1;
            len = 20 + int'($urandom_range(0, 40));
            a0  = int'($urandom_range(0, 10));
            a1  = a0 + int'($urandom_range(0, 45));
            run_line(len, a0, a1, 1 + int'($urandom_range(0, 5)),
                     (k % 5 == 0) ? 1 + int'($urandom_range(0, 8)) : -1, k * 11);
        end
        run_line(20, 0, 0, 3, -1, 99);
        done = 1;
    end

    initial begin
        wait (done || cyc > 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got cyc=%0d exp done", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule